// File: doc/BRIEF.md
# Timestamped Input Change Recorder

This block watches a wide group of digital input lines and keeps a log of their changes only. Every scan period, set by a programmable divider, it takes one sample of all lines. It compares that sample with the sample from the previous scan. When at least one line that the trigger mask allows has changed, it writes a record into an internal FIFO. A record holds the scan timestamp and the complete state of every line. Scans in which nothing changed leave no trace, so a long, mostly quiet capture stays compact.

The lines are grouped into banks of equal width. The defaults are four banks of 16 lines each. Every line passes through a two-flop synchronizer before it is compared. Start opens a capture, and stop ends it. A host drains the records through a show-ahead read port. An empty flag tells the host when no record is waiting. A sticky overflow flag tells it that records were lost.

Top module: `chgrec_top`

## Requirements
- R1: After reset, `empty_o` is 1, `overflow_o` is 0, and no scanning takes place.
- R2: While capturing, the lines are sampled once every `scan_div_i`+1 clocks. Scan n, counted from 0 after the start edge, uses the input value held at clock edge (n+1)(`scan_div_i`+1)−2 after start, because of the two synchronizer flops. A pulse that is not present at that edge produces no record.
- R3: The timestamp is a 32-bit count of scans. It is zero for the first scan after start and rises by one for each later scan. A record carries the count of the scan that produced it.
- R4: The first scan after start always writes a record, whatever the inputs and the mask.
- R5: Every later scan writes a record only if some line whose `trig_mask_i` bit is 1 differs from the previous scan. A scan with no such change writes nothing. The previous-scan value advances on every scan, whether or not a record is written.
- R6: The state field of a record holds the sampled value of all lines, including lines that are masked out and lines that did not change.
- R7: When a record is due and the FIFO already holds DEPTH (default 16) records, the new record is discarded. `overflow_o` then goes to 1 and stays at 1 until the next start.
- R8: Start empties the FIFO, clears `overflow_o`, and restarts the divider and the timestamp. Start takes priority over stop in the same cycle. After stop, no more scans or records occur until the next start.
- R9: The read port is show-ahead. While `empty_o` is 0, `rd_ts_o` and `rd_state_o` present the oldest record, and `rd_en_i` removes it at the clock edge. `rd_en_i` has no effect while `empty_o` is 1. A record becomes visible in the cycle after the edge that completes its scan, which is edge (n+1)(`scan_div_i`+1) after start.
- R10: Records leave the FIFO in the order of their timestamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a capture; pulse for one cycle |
| stop_i | input | 1 | End a capture; pulse for one cycle |
| scan_div_i | input | 16 | The scan period is this value plus one clock |
| din_i | input | 64 | Monitored input lines, asynchronous |
| trig_mask_i | input | 64 | A 1 lets the line start a record |
| rd_en_i | input | 1 | Remove the oldest record |
| rd_ts_o | output | 32 | Timestamp of the oldest record |
| rd_state_o | output | 64 | Line state of the oldest record |
| empty_o | output | 1 | No record is waiting |
| overflow_o | output | 1 | A record was dropped since start (sticky) |

## Verification
The bench holds each input pattern across one whole scan window. The pattern is applied just after the edge that closes the previous scan, so the synchronized sample is settled two edges before the next scan completes. A record is due one clock after the edge that completes its scan. The bench therefore checks `empty_o` in the cycle before that edge and again in the cycle after it. Flags and read data are sampled on the falling edge, and every removal uses `rd_en_i` for exactly one cycle. The overflow and restart effects come from registers, so they are checked one cycle after the stimulus that causes them.

// File: rtl/chgrec_pkg.sv
package chgrec_pkg;

    typedef enum logic {
        SCAN_IDLE   = 1'b0,
        SCAN_ACTIVE = 1'b1
    } scan_state_e;

endpackage

// File: rtl/chgrec_sync.sv
module chgrec_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d        = q;
        d.meta   = async_i;
        d.stable = q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_o = q.stable;

endmodule

// File: rtl/chgrec_scan_timer.sv
module chgrec_scan_timer
    import chgrec_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic [TS_W-1:0]  ts_o
);

    typedef struct packed {
        scan_state_e      state;
        logic [DIV_W-1:0] cnt;
        logic [TS_W-1:0]  ts;
    } timer_t;

    timer_t q, d;
    logic   tick;

    always_comb begin
        d    = q;
        tick = (q.state == SCAN_ACTIVE) && (q.cnt >= div_i);
        if (start_i) begin
            d.state = SCAN_ACTIVE;
            d.cnt   = '0;
            d.ts    = '0;
        end else if (stop_i) begin
            d.state = SCAN_IDLE;
            d.cnt   = '0;
        end else if (q.state == SCAN_ACTIVE) begin
            if (tick) begin
                d.cnt = '0;
                d.ts  = q.ts + 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SCAN_IDLE, cnt: '0, ts: '0};
        end else begin
            q <= d;
        end
    end

    assign tick_o = tick;
    assign ts_o   = q.ts;

    // R3: every completed scan advances the timestamp by exactly one
    p_ts_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !start_i && !stop_i) |=> (ts_o == $past(ts_o) + 1'b1));

    // R8: a stop without start leaves no scan in the following cycle
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !tick_o);

    // R3: start brings the timestamp back to zero
    p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (ts_o == '0));

endmodule

// File: rtl/chgrec_detect.sv
module chgrec_detect #(
    parameter int BANK_W  = 16,
    parameter int N_BANKS = 4,
    localparam int N_LINES = BANK_W * N_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               tick_i,
    input  logic [N_LINES-1:0] sample_i,
    input  logic [N_LINES-1:0] mask_i,
    output logic               push_o
);

    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic               first;
    } det_t;

    det_t               q, d;
    logic [N_BANKS-1:0] bank_hit;
    logic               push;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign bank_hit[b] = |((sample_i[b*BANK_W +: BANK_W] ^ q.prev[b*BANK_W +: BANK_W])
                               & mask_i[b*BANK_W +: BANK_W]);
    end

    always_comb begin
        d    = q;
        push = 1'b0;
        if (start_i) begin
            d.first = 1'b1;
        end else if (tick_i) begin
            push    = q.first | (|bank_hit);
            d.prev  = sample_i;
            d.first = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{prev: '0, first: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign push_o = push;

    // R4: the first scan after a start is always logged
    p_first_logged_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (tick_i && !start_i) |-> push_o);

endmodule

// File: rtl/chgrec_fifo.sv
module chgrec_fifo #(
    parameter int WIDTH = 96,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t             q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr_ok;
    logic             rd_ok;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == FULL_CNT);

    always_comb begin
        d     = q;
        wr_ok = wr_en_i && !full_o && !flush_i;
        rd_ok = rd_en_i && !empty_o && !flush_i;
        if (flush_i) begin
            d = '0;
        end else begin
            if (wr_ok) begin
                d.wr_ptr = (q.wr_ptr == LAST_IDX) ? '0 : q.wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                d.rd_ptr = (q.rd_ptr == LAST_IDX) ? '0 : q.rd_ptr + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   d.cnt = q.cnt + 1'b1;
                2'b01:   d.cnt = q.cnt - 1'b1;
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[q.wr_ptr] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[q.rd_ptr];

    // R7: a write offered to a full buffer leaves its fill level unchanged
    p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && wr_en_i && !rd_en_i && !flush_i) |=> (full_o && $stable(q.cnt)));

    // R9: reading an empty buffer changes nothing
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && rd_en_i && !wr_en_i && !flush_i) |=> (empty_o && $stable(q.rd_ptr)));

    // R10: the fill level never exceeds the depth
    p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL_CNT);

endmodule

// File: rtl/chgrec_top.sv
module chgrec_top #(
    parameter int BANK_W  = 16,
    parameter int N_BANKS = 4,
    parameter int TS_W    = 32,
    parameter int DIV_W   = 16,
    parameter int DEPTH   = 16,
    localparam int N_LINES = BANK_W * N_BANKS,
    localparam int REC_W   = TS_W + N_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [DIV_W-1:0]   scan_div_i,
    input  logic [N_LINES-1:0] din_i,
    input  logic [N_LINES-1:0] trig_mask_i,
    input  logic               rd_en_i,
    output logic [TS_W-1:0]    rd_ts_o,
    output logic [N_LINES-1:0] rd_state_o,
    output logic               empty_o,
    output logic               overflow_o
);

    typedef struct packed {
        logic ovf;
    } top_t;

    top_t               q, d;
    logic [N_LINES-1:0] sampled;
    logic               tick;
    logic [TS_W-1:0]    ts_now;
    logic               push;
    logic               fifo_full;
    logic [REC_W-1:0]   rec_out;

    chgrec_sync #(.WIDTH(N_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (din_i),
        .sync_o  (sampled)
    );

    chgrec_scan_timer #(.DIV_W(DIV_W), .TS_W(TS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop_i),
        .div_i   (scan_div_i),
        .tick_o  (tick),
        .ts_o    (ts_now)
    );

    chgrec_detect #(.BANK_W(BANK_W), .N_BANKS(N_BANKS)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .tick_i   (tick),
        .sample_i (sampled),
        .mask_i   (trig_mask_i),
        .push_o   (push)
    );

    chgrec_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (start_i),
        .wr_en_i   (push),
        .wr_data_i ({ts_now, sampled}),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rec_out),
        .empty_o   (empty_o),
        .full_o    (fifo_full)
    );

    always_comb begin
        d = q;
        if (start_i) begin
            d.ovf = 1'b0;
        end else if (push && fifo_full) begin
            d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign overflow_o = q.ovf;
    assign rd_ts_o    = rec_out[REC_W-1 -: TS_W];
    assign rd_state_o = rec_out[N_LINES-1:0];

    // R7: a record lost to a full buffer raises the flag
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_full && !start_i) |=> overflow_o);

    // R7: the flag stays up until a start
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !start_i) |=> overflow_o);

    // R8: start leaves an empty buffer and a cleared flag
    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (empty_o && !overflow_o));

    // R5: records are only produced on a completed scan
    p_push_on_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tick);

endmodule

// File: tb/chgrec_top_tb.sv
module chgrec_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 64;
    localparam int DEPTH      = 16;
    localparam int NV         = 10;

    localparam logic [63:0] V_DIN [NV] = '{
        64'h0000_0000_0000_0000,
        64'h0000_0000_0000_0000,
        64'h0000_0000_0000_0001,
        64'h0000_0100_0000_0001,
        64'h0000_0100_0000_0001,
        64'h8000_0100_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hA5A5_A5A5_A5A5_A5A5,
        64'hA5A5_A5A5_A5A7_A5A5
    };
    localparam logic [63:0] V_MASK [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_FFFF,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000,
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_FFFF_0000_0000,
        64'h0000_0000_FFFF_0000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [15:0]   scan_div_i = 16'd3;
    logic [NL-1:0] din_i = '0;
    logic [NL-1:0] trig_mask_i = '1;
    logic          rd_en_i = 1'b0;
    logic [31:0]   rd_ts_o;
    logic [NL-1:0] rd_state_o;
    logic          empty_o;
    logic          overflow_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [31:0] exp_ts [DEPTH];
    logic [63:0] exp_st [DEPTH];
    int          n_exp;
    logic [31:0] got_ts;
    logic [63:0] got_st;

    chgrec_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .scan_div_i  (scan_div_i),
        .din_i       (din_i),
        .trig_mask_i (trig_mask_i),
        .rd_en_i     (rd_en_i),
        .rd_ts_o     (rd_ts_o),
        .rd_state_o  (rd_state_o),
        .empty_o     (empty_o),
        .overflow_o  (overflow_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_run(input logic [15:0] div);
        @(negedge clk);
        scan_div_i = div;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic stop_run();
        stop_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic wait_scans(input int k, input int period);
        repeat (k * period) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pop(output logic [31:0] ts, output logic [63:0] st);
        ts = rd_ts_o;
        st = rd_state_o;
        rd_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic drain_and_compare(input string tag);
        for (int i = 0; i < n_exp; i++) begin
            check(!empty_o, {tag, " R9 record present"}, empty_o, 1'b0);
            pop(got_ts, got_st);
            check(got_ts == exp_ts[i], {tag, " R3/R10 timestamp"}, got_ts, exp_ts[i]);
            check(got_st == exp_st[i], {tag, " R6 state"}, got_st, exp_st[i]);
        end
        check(empty_o, {tag, " R5 no extra records"}, empty_o, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] prev;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(empty_o, "R1 empty after reset", empty_o, 1'b1);
        check(!overflow_o, "R1 overflow after reset", overflow_o, 1'b0);
        rst_n = 1'b1;
        din_i = V_DIN[0];
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(empty_o, "R1 idle before start", empty_o, 1'b1);

        // table walk, period 4: R4 R5 R6
        n_exp = 0;
        prev = '0;
        for (int n = 0; n < NV; n++) begin
            if (n == 0 || ((V_DIN[n] ^ prev) & V_MASK[n]) != 0) begin
                exp_ts[n_exp] = 32'(n);
                exp_st[n_exp] = V_DIN[n];
                n_exp++;
            end
            prev = V_DIN[n];
        end
        start_run(16'd3);
        for (int n = 0; n < NV; n++) begin
            din_i = V_DIN[n];
            trig_mask_i = V_MASK[n];
            wait_scans(1, 4);
        end
        stop_run();
        drain_and_compare("table");

        // R8: stopped capture ignores changes
        trig_mask_i = '1;
        for (int k = 0; k < 3; k++) begin
            din_i = ~din_i;
            wait_scans(1, 4);
        end
        check(empty_o, "R8 no record after stop", empty_o, 1'b1);

        // R9: read on empty has no effect
        rd_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en_i = 1'b0;
        check(empty_o, "R9 read while empty", empty_o, 1'b1);

        // R2: period 10, short pulse missed; R9 record timing
        din_i = '0;
        repeat (4) @(posedge clk);
        start_run(16'd9);
        repeat (9) @(posedge clk);
        @(negedge clk);
        check(empty_o, "R9 not yet visible", empty_o, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check(!empty_o, "R9 visible after scan edge", empty_o, 1'b0);
        din_i = 64'h20;
        @(negedge clk);
        din_i = '0;
        repeat (9) @(posedge clk);
        @(negedge clk);
        din_i = 64'h20;
        wait_scans(1, 10);
        stop_run();
        n_exp = 2;
        exp_ts[0] = 0; exp_st[0] = '0;
        exp_ts[1] = 2; exp_st[1] = 64'h20;
        drain_and_compare("R2 pulse");

        // R7: overflow with period 4
        start_run(16'd3);
        for (int n = 0; n < 20; n++) begin
            din_i = {64{n[0]}};
            wait_scans(1, 4);
        end
        stop_run();
        check(overflow_o, "R7 overflow set", overflow_o, 1'b1);
        n_exp = DEPTH;
        for (int i = 0; i < DEPTH; i++) begin
            exp_ts[i] = 32'(i);
            exp_st[i] = {64{i[0]}};
        end
        drain_and_compare("R7 full");
        check(overflow_o, "R7 overflow sticky after drain", overflow_o, 1'b1);

        // R8: restart clears flag and buffer
        start_run(16'd3);
        check(!overflow_o, "R8 restart clears overflow", overflow_o, 1'b0);
        check(empty_o, "R8 restart empties", empty_o, 1'b1);
        stop_run();

        // R8: start wins over stop
        @(negedge clk);
        start_i = 1'b1;
        stop_i = 1'b1;
        scan_div_i = 16'd3;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        stop_i = 1'b0;
        wait_scans(1, 4);
        check(!empty_o, "R8 start beats stop", empty_o, 1'b0);
        pop(got_ts, got_st);
        check(got_ts == 0, "R3 first timestamp zero", got_ts, 32'd0);
        stop_run();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule